// File: doc/BRIEF.md
# RMII Transmit Di-bit Serializer

This block is the transmit half of a MAC-side Reduced Media Independent Interface. It accepts one Ethernet frame at a time as a byte stream on a valid/ready/last handshake. It then produces the 2-bit transmit data bus and its enable on the shared 50 MHz reference clock. Ahead of the caller's bytes it inserts seven preamble bytes and the start-of-frame delimiter. Every byte leaves as four di-bits, lowest pair first. The caller supplies the payload, which includes any frame check sequence it wants on the wire.

At 100 Mb/s a new di-bit appears on every reference clock. When the speed-select input asks for 10 Mb/s at frame start, every di-bit and its enable are held for ten reference clocks instead. Between frames the block keeps the enable low and the data bus at zero for a fixed idle gap. A caller that keeps its valid high during that gap gets the next frame started as soon as the gap has run out.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is asserted and right after it, tx_en is 0, txd is 2'b00 and in_ready is 0.
- R2: Whenever tx_en is 0, txd is 2'b00, whatever in_data, in_last and in_valid carry.
- R3: In idle, tx_en rises, carrying the first preamble di-bit, on the clock edge at which in_valid is first sampled high.
- R4: Each frame opens with 32 di-bits: seven bytes of 0x55 followed by 0xD5. On txd this is 2'b01 thirty-one times and then 2'b11.
- R5: Every byte is sent as four di-bits in the order bits [1:0], [3:2], [5:4], [7:6], with payload bytes in the order they were accepted.
- R6: in_ready is high for exactly one clock per byte: the final clock of the last di-bit of the delimiter and of each payload byte not flagged last. A byte is taken when in_valid and in_ready are both high.
- R7: tx_en stays high without a gap from the first preamble di-bit through the last di-bit of the byte flagged last. It falls on the next edge, so a frame of N payload bytes keeps tx_en high for 32+4N di-bit periods.
- R8: If in_valid is low in a clock where in_ready is high, no byte is taken and tx_en falls on the next edge, ending the frame after the bytes already sent.
- R9: After tx_en falls it stays low for at least 48 di-bit periods. If in_valid is waiting, the next frame starts exactly 48 di-bit periods after the fall.
- R10: With 10 Mb/s selected (slow_sel = 1), every di-bit and the matching tx_en value are held for 10 consecutive clocks, and in_ready is high only in the last of those clocks.
- R11: slow_sel is sampled only while idle, on the edge at which a frame starts. Changing it during a frame or its gap does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_sel | input | 1 | 1 selects 10 Mb/s di-bit pacing, 0 selects 100 Mb/s |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of the frame |
| in_ready | output | 1 | Byte accepted this clock when in_valid is high |
| tx_en | output | 1 | Transmit enable |
| txd | output | 2 | Transmit di-bit |

## Verification
The bench goes after the edges of the enable. If the enable rose one clock late, the frame would shift in time. If it fell one clock late, the receiver would see an extra di-bit of zeros. Both show up in the exact rise and fall cycles it measures. An all-zero payload byte checks that the enable alone marks the frame and not a nonzero bus. A payload starved partway through checks that the frame is cut short rather than padded with stale data. Back-to-back frames at both speeds check the exact gap length. Flipping the speed select mid-frame checks that pacing is frozen at frame start. Slow-mode ready counting catches a ready signal that stays high across the ten-clock hold and would swallow ten bytes at once.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_SFD  = 3'd2,
    PH_DATA = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

endpackage

// File: rtl/rmii_tx_pace.sv
module rmii_tx_pace #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow_sel,
  output logic tick
);

  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             slow_q, slow_d;
  logic             cnt_en;

  assign tick   = run && (!slow_q || (cnt_q == DIV_LAST));
  assign cnt_en = !run || slow_q;

  always_comb begin
    slow_d = run ? slow_q : slow_sel;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
    end else begin
      slow_q <= slow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R10
  slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slow_q) |=> !tick);

endmodule

// File: rtl/rmii_tx_framer.sv
module rmii_tx_framer
  import rmii_tx_pkg::*;
#(
  parameter int PRE_BYTES  = 7,
  parameter int GAP_DIBITS = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       run,
  output phase_e     phase,
  output logic [1:0] idx,
  output logic [7:0] byte_out
);

  localparam int PRE_W = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam int GAP_W = (GAP_DIBITS > 1) ? $clog2(GAP_DIBITS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_BYTES - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_DIBITS - 1);

  phase_e           phase_q, phase_d;
  logic [1:0]       idx_q, idx_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [GAP_W-1:0] gap_cnt_q, gap_cnt_d;
  logic [7:0]       byte_q;
  logic             last_q;
  logic             byte_end;
  logic             load_en;

  assign byte_end = tick && (idx_q == 2'd3);
  assign in_ready = byte_end &&
                    ((phase_q == PH_SFD) || ((phase_q == PH_DATA) && !last_q));
  assign load_en  = in_ready && in_valid;
  assign run      = (phase_q != PH_IDLE);
  assign phase    = phase_q;
  assign idx      = idx_q;
  assign byte_out = byte_q;

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    pre_cnt_d = pre_cnt_q;
    gap_cnt_d = gap_cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (in_valid) begin
          phase_d   = PH_PRE;
          idx_d     = 2'd0;
          pre_cnt_d = '0;
        end
      end
      PH_PRE: begin
        if (tick) begin
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            if (pre_cnt_q == PRE_LAST) begin
              phase_d = PH_SFD;
            end else begin
              pre_cnt_d = pre_cnt_q + 1'b1;
            end
          end
        end
      end
      PH_SFD, PH_DATA: begin
        if (tick) begin
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            if (load_en) begin
              phase_d = PH_DATA;
            end else begin
              phase_d   = PH_GAP;
              gap_cnt_d = '0;
            end
          end
        end
      end
      PH_GAP: begin
        if (tick) begin
          if (gap_cnt_q == GAP_LAST) begin
            if (in_valid) begin
              phase_d   = PH_PRE;
              idx_d     = 2'd0;
              pre_cnt_d = '0;
            end else begin
              phase_d = PH_IDLE;
            end
          end else begin
            gap_cnt_d = gap_cnt_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      idx_q     <= 2'd0;
      pre_cnt_q <= '0;
      gap_cnt_q <= '0;
    end else begin
      phase_q   <= phase_d;
      idx_q     <= idx_d;
      pre_cnt_q <= pre_cnt_d;
      gap_cnt_q <= gap_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= 8'h00;
      last_q <= 1'b0;
    end else if (load_en) begin
      byte_q <= in_data;
      last_q <= in_last;
    end
  end

  // R6
  ready_at_byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (idx_q == 2'd0));

  // R8
  underrun_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (phase_q == PH_GAP));

endmodule

// File: rtl/rmii_tx_dibit_mux.sv
module rmii_tx_dibit_mux
  import rmii_tx_pkg::*;
(
  input  phase_e     phase,
  input  logic [1:0] idx,
  input  logic [7:0] byte_in,
  output logic       tx_en,
  output logic [1:0] txd
);

  logic [7:0] cur;

  always_comb begin
    tx_en = (phase == PH_PRE) || (phase == PH_SFD) || (phase == PH_DATA);
    unique case (phase)
      PH_PRE:  cur = PRE_BYTE;
      PH_SFD:  cur = SFD_BYTE;
      default: cur = byte_in;
    endcase
    txd = tx_en ? cur[{idx, 1'b0} +: 2] : 2'b00;
  end

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
#(
  parameter int SLOW_DIV   = 10,
  parameter int PRE_BYTES  = 7,
  parameter int GAP_DIBITS = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_sel,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_en,
  output logic [1:0] txd
);

  localparam int LOW_W = $clog2(GAP_DIBITS + 1);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(GAP_DIBITS);

  logic       tick_w;
  logic       run_w;
  phase_e     phase_w;
  logic [1:0] idx_w;
  logic [7:0] byte_w;

  rmii_tx_pace #(
    .SLOW_DIV (SLOW_DIV)
  ) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .slow_sel (slow_sel),
    .tick     (tick_w)
  );

  rmii_tx_framer #(
    .PRE_BYTES  (PRE_BYTES),
    .GAP_DIBITS (GAP_DIBITS)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .run      (run_w),
    .phase    (phase_w),
    .idx      (idx_w),
    .byte_out (byte_w)
  );

  rmii_tx_dibit_mux u_mux (
    .phase   (phase_w),
    .idx     (idx_w),
    .byte_in (byte_w),
    .tx_en   (tx_en),
    .txd     (txd)
  );

  // Checker state: clocks spent with tx_en low, saturating at the gap length.
  logic [LOW_W-1:0] low_cnt_q, low_cnt_d;

  always_comb begin
    if (tx_en) begin
      low_cnt_d = '0;
    end else if (low_cnt_q != LOW_SAT) begin
      low_cnt_d = low_cnt_q + 1'b1;
    end else begin
      low_cnt_d = low_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= LOW_SAT;
    end else begin
      low_cnt_q <= low_cnt_d;
    end
  end

  // R2
  idle_txd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 2'b00));

  // R4
  first_dibit_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == 2'b01));

  // R6
  ready_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);

  // R9
  gap_minimum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (low_cnt_q >= LOW_SAT));

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tick_w) |=> ($stable(txd) && $stable(tx_en)));

endmodule

// File: tb/rmii_tx_serializer_tb.sv
module rmii_tx_serializer_tb;

  localparam int CLK_PERIOD = 20;
  localparam int HOLD_SLOW  = 10;
  localparam int PRE        = 7;
  localparam int GAP        = 48;
  localparam int CAP_MAX    = 2048;

  logic       clk;
  logic       rst_n;
  logic       slow_sel;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic       tx_en;
  logic [1:0] txd;

  int checks = 0;
  int errors = 0;

  logic [7:0] payload [0:15];
  logic [1:0] cap [0:CAP_MAX-1];
  int cap_len, rise_cyc, fall_cyc, ready_cnt, consumed, idle_bad;

  rmii_tx_serializer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_sel (slow_sel),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .tx_en    (tx_en),
    .txd      (txd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_wait(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Drives one frame and records the wire activity relative to the first
  // sampling point after in_valid is raised.
  task automatic run_frame(input int n, input int limit, input int toggle_at,
                           input int max_cyc);
    int  pos = 0;
    bit  pend = 0;
    bit  seen_rise = 0;
    bit  fallen = 0;
    cap_len = 0; ready_cnt = 0; consumed = 0; idle_bad = 0;
    rise_cyc = -1; fall_cyc = -1;
    @(negedge clk);
    in_valid = (limit > 0);
    in_data  = payload[0];
    in_last  = (n == 1);
    for (int cyc = 0; cyc < max_cyc; cyc++) begin
      @(negedge clk);
      if (pend) begin
        pos++;
        pend = 0;
        if (pos < n && pos < limit) begin
          in_data = payload[pos];
          in_last = (pos == n - 1);
        end else begin
          in_valid = 1'b0;
          in_last  = 1'b0;
          in_data  = 8'hA5;
        end
      end
      if (cyc == toggle_at) slow_sel = ~slow_sel;
      if (tx_en) begin
        if (!seen_rise) begin
          seen_rise = 1;
          rise_cyc  = cyc;
        end
        if (cap_len < CAP_MAX) begin
          cap[cap_len] = txd;
          cap_len++;
        end
      end else begin
        if (txd != 2'b00) idle_bad++;
        if (seen_rise) begin
          fallen   = 1;
          fall_cyc = cyc;
        end
      end
      if (in_ready) begin
        ready_cnt++;
        if (in_valid) begin
          pend = 1;
          consumed++;
        end
      end
      if (fallen) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic check_stream(input string req, input int nbytes, input int hold);
    int idx = 0;
    int bad = -1;
    logic [7:0] b;
    for (int k = 0; k < PRE + 1 + nbytes; k++) begin
      b = (k < PRE) ? 8'h55 : (k == PRE) ? 8'hD5 : payload[k-PRE-1];
      for (int d = 0; d < 4; d++) begin
        for (int h = 0; h < hold; h++) begin
          if (idx < cap_len && bad < 0 && cap[idx] !== b[2*d +: 2]) bad = idx;
          idx++;
        end
      end
    end
    check(cap_len == idx, req, "dibit count", cap_len, idx);
    check(bad < 0, req, "first wrong dibit index", bad, -1);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; slow_sel = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
    check(txd == 2'b00, "R1", "txd in reset", txd, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_en && txd == 2'b00 && !in_ready, "R1", "outputs after reset",
          {tx_en, txd, in_ready}, 0);
  endtask

  task automatic test_idle_ignored;
    int bad = 0;
    in_valid = 1'b0; in_data = 8'hFF; in_last = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_en || txd != 2'b00 || in_ready) bad++;
    end
    in_last = 1'b0;
    check(bad == 0, "R2", "idle cycles with activity", bad, 0);
  endtask

  task automatic test_fast_frame;
    payload[0] = 8'h1B; payload[1] = 8'hE4; payload[2] = 8'h3C; payload[3] = 8'h96;
    run_frame(4, 4, -1, 1000);
    check(rise_cyc == 0, "R3", "tx_en rise cycle", rise_cyc, 0);
    check_stream("R4/R5", 4, 1);
    check(ready_cnt == 4, "R6", "ready pulses", ready_cnt, 4);
    check(consumed == 4, "R6", "bytes taken", consumed, 4);
    check(fall_cyc == 32 + 16, "R7", "tx_en fall cycle", fall_cyc, 48);
    check(idle_bad == 0, "R2", "nonzero txd while disabled", idle_bad, 0);
    idle_wait(60);
  endtask

  task automatic test_zero_byte;
    payload[0] = 8'h00;
    run_frame(1, 1, -1, 1000);
    check_stream("R5", 1, 1);
    check(fall_cyc == 36, "R7", "tx_en fall with zero byte", fall_cyc, 36);
    check(ready_cnt == 1, "R6", "ready pulses single byte", ready_cnt, 1);
    idle_wait(60);
  endtask

  task automatic test_underrun;
    payload[0] = 8'h5A; payload[1] = 8'hC3; payload[2] = 8'h0F;
    run_frame(3, 1, -1, 1000);
    check_stream("R8", 1, 1);
    check(fall_cyc == 36, "R8", "tx_en fall on starvation", fall_cyc, 36);
    check(consumed == 1, "R8", "bytes taken", consumed, 1);
    check(ready_cnt == 2, "R8", "ready pulses", ready_cnt, 2);
    idle_wait(60);
  endtask

  task automatic test_back_to_back(input bit slow, input string tag);
    int hold = slow ? HOLD_SLOW : 1;
    slow_sel = slow;
    payload[0] = 8'h81; payload[1] = 8'h7E;
    run_frame(2, 2, -1, 5000);
    run_frame(2, 2, -1, 5000);
    check(rise_cyc == GAP * hold - 2, tag, "second frame rise cycle",
          rise_cyc, GAP * hold - 2);
    check_stream(tag, 2, hold);
    check(idle_bad == 0, "R2", "nonzero txd in gap", idle_bad, 0);
    idle_wait(600);
    slow_sel = 1'b0;
  endtask

  task automatic test_slow_frame;
    slow_sel = 1'b1;
    payload[0] = 8'h27; payload[1] = 8'hB8;
    run_frame(2, 2, -1, 5000);
    check(rise_cyc == 0, "R10", "slow rise cycle", rise_cyc, 0);
    check_stream("R10", 2, HOLD_SLOW);
    check(fall_cyc == HOLD_SLOW * 40, "R10", "slow fall cycle", fall_cyc, HOLD_SLOW * 40);
    check(ready_cnt == 2, "R10", "slow ready pulses", ready_cnt, 2);
    idle_wait(600);
    slow_sel = 1'b0;
  endtask

  task automatic test_mode_frozen;
    slow_sel = 1'b0;
    payload[0] = 8'hC6; payload[1] = 8'h39;
    run_frame(2, 2, 10, 5000);
    check_stream("R11", 2, 1);
    check(fall_cyc == 40, "R11", "fast frame fall after toggle", fall_cyc, 40);
    idle_wait(600);
    slow_sel = 1'b1;
    run_frame(2, 2, 50, 5000);
    check_stream("R11", 2, HOLD_SLOW);
    check(fall_cyc == HOLD_SLOW * 40, "R11", "slow frame fall after toggle",
          fall_cyc, HOLD_SLOW * 40);
    idle_wait(600);
    slow_sel = 1'b0;
  endtask

  initial begin
    test_reset();
    test_idle_ignored();
    test_fast_frame();
    test_zero_byte();
    test_underrun();
    test_back_to_back(1'b0, "R9");
    test_slow_frame();
    test_back_to_back(1'b1, "R9");
    test_mode_frozen();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule